// File: doc/BRIEF.md
# Serial Code Lock

The block watches a single serial data input, one bit per rising clock edge, and compares it with a fixed unlock code. It starts out idle with the lock engaged. Each bit that matches the next code bit moves it one step further. Once every code bit has matched in order, the lock opens. Any bit that does not match sends it to an alarm condition, and that condition lasts until the block is reset. While the lock is open, a run of 1 bits keeps it open. A 0 bit closes it again and returns it to idle, with no alarm raised.

Both outputs come straight from dedicated flip-flops, so they cannot glitch. The next value of the lock flop is computed from the same conditions that move the state into or out of the open state. As a result the lock output drops on the same edge that opens the lock, with no added cycle. The state register uses a hybrid encoding. One bit marks the alarm state and one bit marks the open state. A small binary counter tracks how far into the code the input has matched.

The data input carries no handshake. It is sampled on every rising edge and there is no back-pressure. Reset is synchronous and active high.

Top module: `serial_code_lock`

## Requirements
- R1: The code is 1,0,0,0,1, applied first bit first. After the fifth matching bit, `locked_o` reads 0 just after the edge that sampled that bit, and `error_o` stays 0.
- R2: A bit that does not match, at any of the five code positions, makes `error_o` read 1 just after the edge that sampled it. `locked_o` stays 1.
- R3: Once `error_o` is 1, it stays 1 and `locked_o` stays 1 for any data input, as long as `rst_i` is 0.
- R4: While the lock is open (`locked_o` = 0), a 1 on `data_i` keeps `locked_o` at 0 after the next edge.
- R5: While the lock is open, a 0 on `data_i` makes `locked_o` 1 and leaves `error_o` at 0 after the next edge. The block is then idle, and a full code opens the lock again.
- R6: A rising edge with `rst_i` = 1 leaves `locked_o` = 1 and `error_o` = 0, from any state and for any `data_i`.
- R7: Before the first clock edge after power-up, `locked_o` = 1 and `error_o` = 0.
- R8: `error_o` = 1 never occurs together with `locked_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; `data_i` is sampled on its rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| data_i | input | 1 | Serial code bit, one per clock |
| locked_o | output | 1 | 1 while the lock is engaged, 0 while it is open |
| error_o | output | 1 | 1 while in the sticky alarm state |

## Verification
Every result is due one edge after its stimulus. The bench applies each bit, and each reset, shortly after a falling edge. It then samples both outputs one time unit after the next rising edge, which is the first point at which the registered outputs can hold the new value. The vector table walks through a full unlock, holding the lock open, closing it, and an alarm that is then cleared by reset. Directed tests place a wrong bit at each of the five code positions, confirm that the alarm ignores the rest of the code, and confirm the power-up values before any edge.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
  // Default unlock code, first bit in the MSB
  localparam int          DEF_CODE_LEN = 5;
  localparam logic [4:0]  DEF_CODE     = 5'b10001;
endpackage

// File: rtl/sclk_expect.sv
module sclk_expect #(
  parameter int                CODE_LEN = 5,
  parameter logic [CODE_LEN-1:0] CODE   = '0,
  localparam int               IDX_W    = $clog2(CODE_LEN)
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic             exp_bit_o,
  output logic             last_pos_o
);
  logic [CODE_LEN-1:0] pick;

  for (genvar k = 0; k < CODE_LEN; k++) begin : g_pos
    assign pick[k] = (idx_i == IDX_W'(k)) & CODE[CODE_LEN-1-k];
  end

  assign exp_bit_o  = |pick;
  assign last_pos_o = (idx_i == IDX_W'(CODE_LEN - 1));
endmodule

// File: rtl/sclk_next.sv
module sclk_next #(
  parameter int  CODE_LEN = 5,
  localparam int IDX_W    = $clog2(CODE_LEN)
) (
  input  logic             err_q_i,
  input  logic             unl_q_i,
  input  logic [IDX_W-1:0] idx_q_i,
  input  logic             data_i,
  input  logic             exp_bit_i,
  input  logic             last_pos_i,
  output logic             err_d_o,
  output logic             unl_d_o,
  output logic [IDX_W-1:0] idx_d_o,
  output logic             locked_d_o
);
  logic matching, hit;

  assign matching = !err_q_i && !unl_q_i;
  assign hit      = (data_i == exp_bit_i);

  always_comb begin
    err_d_o = err_q_i;
    unl_d_o = unl_q_i;
    idx_d_o = idx_q_i;
    if (err_q_i) begin
      // absorbing
    end else if (unl_q_i) begin
      if (!data_i) begin
        unl_d_o = 1'b0;
        idx_d_o = '0;
      end
    end else if (hit) begin
      if (last_pos_i) begin
        unl_d_o = 1'b1;
        idx_d_o = '0;
      end else begin
        idx_d_o = idx_q_i + 1'b1;
      end
    end else begin
      err_d_o = 1'b1;
      idx_d_o = '0;
    end
  end

  // Lock flop input from the same conditions that enter or keep the open state
  assign locked_d_o = !((matching && last_pos_i && hit) || (unl_q_i && data_i));

  // R8
  always_comb begin
    excl_next_chk: assert ($onehot0({err_d_o, unl_d_o}));
  end
endmodule

// File: rtl/sclk_regs.sv
module sclk_regs #(
  parameter int  CODE_LEN = 5,
  localparam int IDX_W    = $clog2(CODE_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             err_d_i,
  input  logic             unl_d_i,
  input  logic [IDX_W-1:0] idx_d_i,
  input  logic             locked_d_i,
  output logic             err_q_o,
  output logic             unl_q_o,
  output logic [IDX_W-1:0] idx_q_o,
  output logic             locked_q_o
);
  logic             err_q    = 1'b0;
  logic             unl_q    = 1'b0;
  logic [IDX_W-1:0] idx_q    = '0;
  logic             locked_q = 1'b1;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      err_q    <= 1'b0;
      unl_q    <= 1'b0;
      idx_q    <= '0;
      locked_q <= 1'b1;
    end else begin
      err_q    <= err_d_i;
      unl_q    <= unl_d_i;
      idx_q    <= idx_d_i;
      locked_q <= locked_d_i;
    end
  end

  assign err_q_o    = err_q;
  assign unl_q_o    = unl_q;
  assign idx_q_o    = idx_q;
  assign locked_q_o = locked_q;

  // R3
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    err_q |=> err_q);
  // R6
  reset_idle_chk: assert property (@(posedge clk_i)
    rst_i |=> (locked_q && !err_q && !unl_q && idx_q == '0));
  // R8
  lock_vs_open_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    locked_q == !unl_q);
  // R1
  idx_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    idx_q < IDX_W'(CODE_LEN));
endmodule

// File: rtl/serial_code_lock.sv
module serial_code_lock
  import sclk_pkg::*;
#(
  parameter int                  CODE_LEN = DEF_CODE_LEN,
  parameter logic [CODE_LEN-1:0] CODE     = DEF_CODE
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic data_i,
  output logic locked_o,
  output logic error_o
);
  localparam int IDX_W = $clog2(CODE_LEN);

  logic             err_q, unl_q, locked_q;
  logic [IDX_W-1:0] idx_q;
  logic             err_d, unl_d, locked_d;
  logic [IDX_W-1:0] idx_d;
  logic             exp_bit, last_pos;

  sclk_expect #(.CODE_LEN(CODE_LEN), .CODE(CODE)) expect_i (
    .idx_i      (idx_q),
    .exp_bit_o  (exp_bit),
    .last_pos_o (last_pos)
  );

  sclk_next #(.CODE_LEN(CODE_LEN)) next_i (
    .err_q_i    (err_q),
    .unl_q_i    (unl_q),
    .idx_q_i    (idx_q),
    .data_i     (data_i),
    .exp_bit_i  (exp_bit),
    .last_pos_i (last_pos),
    .err_d_o    (err_d),
    .unl_d_o    (unl_d),
    .idx_d_o    (idx_d),
    .locked_d_o (locked_d)
  );

  sclk_regs #(.CODE_LEN(CODE_LEN)) regs_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .err_d_i    (err_d),
    .unl_d_i    (unl_d),
    .idx_d_i    (idx_d),
    .locked_d_i (locked_d),
    .err_q_o    (err_q),
    .unl_q_o    (unl_q),
    .idx_q_o    (idx_q),
    .locked_q_o (locked_q)
  );

  assign locked_o = locked_q;
  assign error_o  = err_q;

  // R4
  open_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!locked_o && data_i) |=> !locked_o);
  // R5
  open_close_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!locked_o && !data_i) |=> (locked_o && !error_o));
  // R8
  no_err_open_chk: assert property (@(posedge clk_i)
    !(error_o && !locked_o));
  // R2
  err_keeps_lock_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(error_o) |-> locked_o);
endmodule

// File: tb/serial_code_lock_tb.sv
module serial_code_lock_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 26;
  localparam logic [4:0] CODE = 5'b10001;

  // {rst, data, expected locked, expected error}
  localparam logic [3:0] VEC [NVEC] = '{
    4'b1010, // R6 reset
    4'b0110, 4'b0010, 4'b0010, 4'b0010,
    4'b0100, // R1 fifth bit opens
    4'b0100, 4'b0100, // R4 held open
    4'b0010, // R5 close on 0
    4'b0110, 4'b0010, 4'b0010, 4'b0010,
    4'b0100, // R1 reopens after close (R5)
    4'b0010, // R5 back to idle
    4'b0011, // R2 wrong first bit
    4'b0111, 4'b0011, 4'b0111, // R3 sticky
    4'b1110, // R6 clears error
    4'b0110, 4'b0010, 4'b0010, 4'b0010, 4'b0100,
    4'b1110  // R6 reset from open
  };
  localparam int VREQ [NVEC] = '{6, 1,1,1,1,1, 4,4, 5, 1,1,1,1,1, 5, 2, 3,3,3, 6, 1,1,1,1,1, 6};

  logic clk = 1'b0;
  logic rst = 1'b0;
  logic data = 1'b0;
  logic locked, error;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_code_lock dut_i (
    .clk_i(clk), .rst_i(rst), .data_i(data),
    .locked_o(locked), .error_o(error)
  );

  task automatic compare(input logic el, input logic ee, input string tag);
    checks++;
    if (locked !== el || error !== ee) begin
      fails++;
      $display("FAIL %s: locked=%b error=%b expected locked=%b error=%b",
               tag, locked, error, el, ee);
    end
    // R8 on every sample
    if (error === 1'b1 && locked === 1'b0) begin
      fails++;
      $display("FAIL R8: locked=%b error=%b expected not both alarm and open",
               locked, error);
    end
  endtask

  task automatic step(input logic r, input logic d, input logic el,
                      input logic ee, input string tag);
    @(negedge clk);
    rst = r;
    data = d;
    @(posedge clk);
    #1;
    compare(el, ee, tag);
  endtask

  initial begin
    #1;
    compare(1'b1, 1'b0, "R7 power-up");

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0],
           $sformatf("R%0d vector %0d", VREQ[i], i));
    end

    // R2 / R3: a wrong bit at each code position
    for (int p = 0; p < 5; p++) begin
      step(1'b1, 1'b0, 1'b1, 1'b0, "R6 reset before R2 case");
      for (int k = 0; k < p; k++)
        step(1'b0, CODE[4-k], 1'b1, 1'b0, "R1 partial match");
      step(1'b0, ~CODE[4-p], 1'b1, 1'b1, $sformatf("R2 wrong bit at position %0d", p));
      for (int k = p + 1; k < 5; k++)
        step(1'b0, CODE[4-k], 1'b1, 1'b1, "R3 rest of code ignored");
      step(1'b0, 1'b1, 1'b1, 1'b1, "R3 sticky on 1");
      step(1'b0, 1'b0, 1'b1, 1'b1, "R3 sticky on 0");
    end

    // R6: reset with data 0 while in error
    step(1'b1, 1'b0, 1'b1, 1'b0, "R6 reset with data 0");
    // R4: long run of ones after opening
    step(1'b0, 1'b1, 1'b1, 1'b0, "R1 bit 0");
    step(1'b0, 1'b0, 1'b1, 1'b0, "R1 bit 1");
    step(1'b0, 1'b0, 1'b1, 1'b0, "R1 bit 2");
    step(1'b0, 1'b0, 1'b1, 1'b0, "R1 bit 3");
    step(1'b0, 1'b1, 1'b0, 1'b0, "R1 bit 4 opens");
    for (int k = 0; k < 8; k++)
      step(1'b0, 1'b1, 1'b0, 1'b0, "R4 stays open");
    step(1'b0, 1'b0, 1'b1, 1'b0, "R5 close");
    step(1'b0, 1'b0, 1'b1, 1'b1, "R2 zero from idle is wrong");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule